// File: doc/BRIEF.md
# Address translation lookaside buffer with two-level table walk

The block turns a 32-bit virtual address into a 32-bit physical address. Every request is first looked up in a small fully associative buffer of recent translations. A hit completes one cycle after the request. A miss starts a hardware walk of an in-memory translation table. The walk reads a first-level descriptor through a one-word read port. If that descriptor points to a coarse second-level table, it reads one more word from that table. The walk then installs the new translation and completes.

A descriptor can map a 1 MB section, a 64 KB large page or a 4 KB small page. Malformed descriptors are reported as a section fault or a page fault, and nothing is installed. Every completed translation also presents a 12-bit permission field and a 4-bit domain. A later access check, which is outside this block, uses them. Software can drop all buffered translations, or only the ones that cover a given address.

Top module: `va_xlat`

## Requirements
- R1: On a miss the first read is at address (ttb_i & 0xFFFFC000) | (va[31:20] << 2), so the low two bits are zero.
- R2: A first-level descriptor with bits [1:0] equal to 0 or 3 ends the walk after that one read. It reports fault_o = 1 (section fault) and installs no entry.
- R3: A first-level code of 2 maps a section. It returns pa_o = {L1[31:20], va[19:0]}, perm_o = L1[11:0] & 0xC0C and dom_o = L1[8:5].
- R4: A first-level code of 1 causes a second read at address (L1 & 0xFFFFFC00) | (va[19:12] << 2).
- R5: A second-level descriptor with bits [1:0] equal to 0 or 3 reports fault_o = 2 (page fault) and installs no entry. dom_o still becomes the L1[8:5] of that walk.
- R6: A second-level code of 1 maps a large page with pa_o = {L2[31:16], va[15:0]}. A code of 2 maps a small page with pa_o = {L2[31:12], va[11:0]}. Both return perm_o = L2[11:0] & 0xFFC and dom_o = L1[8:5].
- R7: A request inside the region of a valid entry completes one cycle after it is accepted. It makes no memory read, sets hit_o = 1 and returns that entry's translation.
- R8: Each install writes the slot at a round-robin index and then advances the index by one modulo ENTRIES. After ENTRIES more installs, the oldest translation is gone.
- R9: A one-cycle pulse on inv_all_i invalidates every entry, so the next request to any region walks again.
- R10: A one-cycle pulse on inv_va_i invalidates only the entries whose region contains inv_addr_i. The other entries keep hitting.
- R11: fault_o encodes 0 = none, 1 = section, 2 = page. On a fault, pa_o and perm_o are 0 and hit_o is 0. A section fault leaves dom_o unchanged.
- R12: mem_req_o and mem_addr_o stay steady until the cycle in which mem_valid_i is high. A translation completes only after the read data it needs has been returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Translation request, taken when ready_o is high |
| va_i | input | 32 | Virtual address of the request |
| ttb_i | input | 32 | Translation table base; bits [13:0] are ignored |
| ready_o | output | 1 | Block is idle and can take a request |
| done_o | output | 1 | One-cycle pulse: result outputs are valid |
| hit_o | output | 1 | Result came from the buffer without a walk |
| fault_o | output | 2 | 0 none, 1 section fault, 2 page fault |
| pa_o | output | 32 | Physical address |
| perm_o | output | 12 | Permission bits of the mapping |
| dom_o | output | 4 | Domain of the last translation or page fault |
| inv_all_i | input | 1 | Invalidate all entries |
| inv_va_i | input | 1 | Invalidate the entries covering inv_addr_i |
| inv_addr_i | input | 32 | Address used by inv_va_i |
| mem_req_o | output | 1 | Descriptor read request |
| mem_addr_o | output | 32 | Descriptor word address |
| mem_valid_i | input | 1 | Read data valid, completes the read |
| mem_rdata_i | input | 32 | Descriptor read data |

## Verification
The bench builds the block with ENTRIES = 4, so that round-robin wrap and eviction of the oldest translation can be reached after a handful of fills. Its memory model returns data after 0, 2 or 3 wait cycles. This exercises both the zero-wait path and the case where requests are held across several cycles. A behavioural model of the table and the buffer predicts, for each request:
- the descriptor addresses,
- the number of reads,
- whether the request hits,
- the final fields.

The stimulus mixes sections, large pages, small pages, all four faulting codes, invalidation by address and invalidation of everything.

// File: rtl/va_xlat_pkg.sv
package va_xlat_pkg;

  typedef enum logic [1:0] {
    MAP_NONE  = 2'd0,
    MAP_SMALL = 2'd1,
    MAP_LARGE = 2'd2,
    MAP_SECT  = 2'd3
  } map_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_SECT = 2'd1,
    FLT_PAGE = 2'd2
  } flt_e;

  typedef struct packed {
    logic [31:0] va;
    logic [31:0] pa;
    logic [11:0] perm;
    logic [3:0]  dom;
    map_e        map;
  } tlb_ent_t;

  localparam logic [31:0] TTB_MASK  = 32'hFFFF_C000;
  localparam logic [31:0] L2B_MASK  = 32'hFFFF_FC00;
  localparam logic [11:0] SECT_PERM = 12'hC0C;
  localparam logic [11:0] PAGE_PERM = 12'hFFC;

  function automatic logic [31:0] map_mask(map_e m);
    case (m)
      MAP_SECT:  return 32'hFFF0_0000;
      MAP_LARGE: return 32'hFFFF_0000;
      MAP_SMALL: return 32'hFFFF_F000;
      default:   return 32'h0000_0000;
    endcase
  endfunction

  function automatic logic [31:0] join_pa(logic [31:0] base, map_e m, logic [31:0] va);
    return (base & map_mask(m)) | (va & ~map_mask(m));
  endfunction

endpackage

// File: rtl/va_xlat_tlb.sv
module va_xlat_tlb
  import va_xlat_pkg::*;
#(
  parameter int ENTRIES = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] lk_va_i,
  output logic        hit_o,
  output logic [31:0] hit_pa_o,
  output logic [11:0] hit_perm_o,
  output logic [3:0]  hit_dom_o,
  input  logic        fill_we_i,
  input  tlb_ent_t    fill_ent_i,
  input  logic        inv_all_i,
  input  logic        inv_va_i,
  input  logic [31:0] inv_addr_i
);

  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1);

  tlb_ent_t           ent_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q;
  logic [IW-1:0]      rr_q;
  logic [ENTRIES-1:0] lk_match;
  logic [ENTRIES-1:0] inv_match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign lk_match[g]  = vld_q[g] &&
                          ((lk_va_i & map_mask(ent_q[g].map)) == ent_q[g].va);
    assign inv_match[g] = vld_q[g] &&
                          ((inv_addr_i & map_mask(ent_q[g].map)) == ent_q[g].va);
  end

  // lowest index wins when regions overlap
  always_comb begin
    hit_o      = 1'b0;
    hit_pa_o   = '0;
    hit_perm_o = '0;
    hit_dom_o  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (lk_match[i]) begin
        hit_o      = 1'b1;
        hit_pa_o   = join_pa(ent_q[i].pa, ent_q[i].map, lk_va_i);
        hit_perm_o = ent_q[i].perm;
        hit_dom_o  = ent_q[i].dom;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      rr_q  <= '0;
    end else begin
      if (inv_all_i)     vld_q <= '0;
      else if (inv_va_i) vld_q <= vld_q & ~inv_match;
      if (fill_we_i) begin
        vld_q[rr_q] <= 1'b1;
        rr_q        <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_we_i) ent_q[rr_q] <= fill_ent_i;
  end

  a_r8_fill_sets_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_we_i |=> vld_q[$past(rr_q)]);

  a_r8_rr_wraps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_we_i && rr_q == LAST |=> rr_q == '0);

  a_r9_inv_all_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_all_i && !fill_we_i |=> vld_q == '0);

  a_r10_inv_va_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_va_i && !inv_all_i && !fill_we_i |=> (vld_q & $past(inv_match)) == '0);

endmodule

// File: rtl/va_xlat_walk.sv
module va_xlat_walk
  import va_xlat_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic [31:0] va_i,
  input  logic [31:0] ttb_i,
  input  logic        hit_i,
  input  logic [31:0] hit_pa_i,
  input  logic [11:0] hit_perm_i,
  input  logic [3:0]  hit_dom_i,
  output logic        mem_req_o,
  output logic [31:0] mem_addr_o,
  input  logic        mem_valid_i,
  input  logic [31:0] mem_rdata_i,
  output logic        fill_we_o,
  output tlb_ent_t    fill_ent_o,
  output logic        ready_o,
  output logic        done_o,
  output logic        hit_o,
  output logic [1:0]  fault_o,
  output logic [31:0] pa_o,
  output logic [11:0] perm_o,
  output logic [3:0]  dom_o
);

  typedef enum logic [1:0] {S_IDLE, S_L1, S_L2} st_e;

  st_e         st_q, st_d;
  logic [31:0] va_q, ttb_q, l1_q;
  logic        done_q, hit_q;
  flt_e        flt_q;
  logic [31:0] pa_q;
  logic [11:0] perm_q;
  logic [3:0]  dom_q;

  logic        fin, fin_hit;
  flt_e        fin_flt;
  logic [31:0] fin_pa;
  logic [11:0] fin_perm;
  logic [3:0]  fin_dom;
  tlb_ent_t    ent;

  assign ready_o   = (st_q == S_IDLE);
  assign mem_req_o = (st_q == S_L1) || (st_q == S_L2);
  assign mem_addr_o = (st_q == S_L2)
                    ? ((l1_q & L2B_MASK) | {20'b0, va_q[19:12], 2'b00})
                    : ((ttb_q & TTB_MASK) | {18'b0, va_q[31:20], 2'b00});

  always_comb begin
    st_d      = st_q;
    fin       = 1'b0;
    fin_hit   = 1'b0;
    fin_flt   = FLT_NONE;
    fin_pa    = '0;
    fin_perm  = '0;
    fin_dom   = dom_q;
    fill_we_o = 1'b0;
    ent       = '0;
    case (st_q)
      S_IDLE: begin
        if (req_i) begin
          if (hit_i) begin
            fin      = 1'b1;
            fin_hit  = 1'b1;
            fin_pa   = hit_pa_i;
            fin_perm = hit_perm_i;
            fin_dom  = hit_dom_i;
          end else begin
            st_d = S_L1;
          end
        end
      end
      S_L1: begin
        if (mem_valid_i) begin
          st_d = S_IDLE;
          case (mem_rdata_i[1:0])
            2'b10: begin
              ent.map  = MAP_SECT;
              ent.va   = va_q & map_mask(MAP_SECT);
              ent.pa   = mem_rdata_i & map_mask(MAP_SECT);
              ent.perm = mem_rdata_i[11:0] & SECT_PERM;
              ent.dom  = mem_rdata_i[8:5];
              fill_we_o = 1'b1;
              fin      = 1'b1;
              fin_pa   = join_pa(ent.pa, MAP_SECT, va_q);
              fin_perm = ent.perm;
              fin_dom  = ent.dom;
            end
            2'b01: st_d = S_L2;
            default: begin
              fin     = 1'b1;
              fin_flt = FLT_SECT;
            end
          endcase
        end
      end
      S_L2: begin
        if (mem_valid_i) begin
          st_d    = S_IDLE;
          fin     = 1'b1;
          fin_dom = l1_q[8:5];
          if (mem_rdata_i[1:0] == 2'b01 || mem_rdata_i[1:0] == 2'b10) begin
            ent.map  = (mem_rdata_i[1:0] == 2'b01) ? MAP_LARGE : MAP_SMALL;
            ent.va   = va_q & map_mask(ent.map);
            ent.pa   = mem_rdata_i & map_mask(ent.map);
            ent.perm = mem_rdata_i[11:0] & PAGE_PERM;
            ent.dom  = l1_q[8:5];
            fill_we_o = 1'b1;
            fin_pa   = join_pa(ent.pa, ent.map, va_q);
            fin_perm = ent.perm;
          end else begin
            fin_flt = FLT_PAGE;
          end
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  assign fill_ent_o = ent;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      va_q   <= '0;
      ttb_q  <= '0;
      l1_q   <= '0;
      done_q <= 1'b0;
      hit_q  <= 1'b0;
      flt_q  <= FLT_NONE;
      pa_q   <= '0;
      perm_q <= '0;
      dom_q  <= '0;
    end else begin
      st_q   <= st_d;
      done_q <= fin;
      if (st_q == S_IDLE && req_i && !hit_i) begin
        va_q  <= va_i;
        ttb_q <= ttb_i;
      end
      if (st_q == S_L1 && mem_valid_i) l1_q <= mem_rdata_i;
      if (fin) begin
        hit_q  <= fin_hit;
        flt_q  <= fin_flt;
        pa_q   <= fin_pa;
        perm_q <= fin_perm;
        dom_q  <= fin_dom;
      end
    end
  end

  assign done_o  = done_q;
  assign hit_o   = hit_q;
  assign fault_o = flt_q;
  assign pa_o    = pa_q;
  assign perm_o  = perm_q;
  assign dom_o   = dom_q;

  a_r12_mem_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_valid_i |=> mem_req_o && $stable(mem_addr_o));

  a_r1_word_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[1:0] == 2'b00);

  a_r7_hit_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && hit_o |-> $past(req_i) && !$past(mem_req_o));

  a_r11_fault_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && fault_o != 2'd0 |-> pa_o == '0 && perm_o == '0 && !hit_o);

  a_r2_fill_no_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_we_o |=> done_o && fault_o == 2'd0 && !hit_o);

  a_r11_code_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> fault_o != 2'd3);

endmodule

// File: rtl/va_xlat.sv
module va_xlat
  import va_xlat_pkg::*;
#(
  parameter int ENTRIES = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic [31:0] va_i,
  input  logic [31:0] ttb_i,
  output logic        ready_o,
  output logic        done_o,
  output logic        hit_o,
  output logic [1:0]  fault_o,
  output logic [31:0] pa_o,
  output logic [11:0] perm_o,
  output logic [3:0]  dom_o,
  input  logic        inv_all_i,
  input  logic        inv_va_i,
  input  logic [31:0] inv_addr_i,
  output logic        mem_req_o,
  output logic [31:0] mem_addr_o,
  input  logic        mem_valid_i,
  input  logic [31:0] mem_rdata_i
);

  logic        lk_hit;
  logic [31:0] lk_pa;
  logic [11:0] lk_perm;
  logic [3:0]  lk_dom;
  logic        fill_we;
  tlb_ent_t    fill_ent;

  va_xlat_tlb #(.ENTRIES(ENTRIES)) u_tlb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lk_va_i    (va_i),
    .hit_o      (lk_hit),
    .hit_pa_o   (lk_pa),
    .hit_perm_o (lk_perm),
    .hit_dom_o  (lk_dom),
    .fill_we_i  (fill_we),
    .fill_ent_i (fill_ent),
    .inv_all_i  (inv_all_i),
    .inv_va_i   (inv_va_i),
    .inv_addr_i (inv_addr_i)
  );

  va_xlat_walk u_walk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .va_i        (va_i),
    .ttb_i       (ttb_i),
    .hit_i       (lk_hit),
    .hit_pa_i    (lk_pa),
    .hit_perm_i  (lk_perm),
    .hit_dom_i   (lk_dom),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_valid_i (mem_valid_i),
    .mem_rdata_i (mem_rdata_i),
    .fill_we_o   (fill_we),
    .fill_ent_o  (fill_ent),
    .ready_o     (ready_o),
    .done_o      (done_o),
    .hit_o       (hit_o),
    .fault_o     (fault_o),
    .pa_o        (pa_o),
    .perm_o      (perm_o),
    .dom_o       (dom_o)
  );

endmodule

// File: tb/va_xlat_tb_top.sv
module va_xlat_tb_top;

  localparam int NE = 4;
  localparam logic [31:0] TTB = 32'h0001_2345;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [31:0] va_i = '0;
  logic [31:0] ttb_i = TTB;
  logic        ready_o, done_o, hit_o;
  logic [1:0]  fault_o;
  logic [31:0] pa_o;
  logic [11:0] perm_o;
  logic [3:0]  dom_o;
  logic        inv_all_i = 1'b0;
  logic        inv_va_i = 1'b0;
  logic [31:0] inv_addr_i = '0;
  logic        mem_req_o;
  logic [31:0] mem_addr_o;
  logic        mem_valid_i;
  logic [31:0] mem_rdata_i;

  int n_chk = 0;
  int n_fail = 0;
  int mem_lat = 0;
  int wcnt = 0;
  logic [31:0] mem [logic [31:0]];
  logic [31:0] addr_log [$];

  // reference model state
  logic        m_vld  [NE];
  logic [31:0] m_va   [NE];
  logic [31:0] m_pa   [NE];
  int          m_map  [NE];
  logic [11:0] m_perm [NE];
  logic [3:0]  m_dom  [NE];
  int          m_rr = 0;
  logic [3:0]  m_last_dom = 4'd0;

  va_xlat #(.ENTRIES(NE)) dut_i (.*);

  always #5 clk_i = ~clk_i;

  function automatic logic [31:0] rd(logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  function automatic logic [31:0] mk(int map);
    return (map == 3) ? 32'hFFF0_0000 : (map == 2) ? 32'hFFFF_0000 : 32'hFFFF_F000;
  endfunction

  function automatic logic [31:0] l1a(logic [31:0] va);
    return (TTB & 32'hFFFF_C000) | ((va >> 18) & ~32'h3);
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // memory responder
  initial begin
    mem_valid_i = 1'b0;
    mem_rdata_i = '0;
    forever begin
      @(negedge clk_i);
      if (mem_valid_i) begin
        mem_valid_i = 1'b0;
        wcnt = 0;
      end else if (mem_req_o) begin
        if (wcnt >= mem_lat) begin
          mem_valid_i = 1'b1;
          mem_rdata_i = rd(mem_addr_o);
          addr_log.push_back(mem_addr_o);
        end else begin
          wcnt++;
        end
      end
    end
  end

  task automatic xlat(logic [31:0] va, string tag);
    logic [31:0] e_pa = '0, e_a1 = '0, e_a2 = '0, d1, d2;
    logic [11:0] e_perm = '0;
    logic [1:0]  e_flt = 2'd0;
    logic        e_hit = 1'b0;
    int          e_reads = 0, hit_idx = -1, map = 0, cyc = 0;
    for (int i = NE - 1; i >= 0; i--)
      if (m_vld[i] && ((va & mk(m_map[i])) == m_va[i])) hit_idx = i;
    if (hit_idx >= 0) begin
      e_hit = 1'b1;
      e_pa = (m_pa[hit_idx] & mk(m_map[hit_idx])) | (va & ~mk(m_map[hit_idx]));
      e_perm = m_perm[hit_idx];
      m_last_dom = m_dom[hit_idx];
    end else begin
      e_a1 = l1a(va);
      d1 = rd(e_a1);
      e_reads = 1;
      if (d1[1:0] == 2'd2) begin
        map = 3;
        e_pa = {d1[31:20], va[19:0]};
        e_perm = d1[11:0] & 12'hC0C;
        m_last_dom = d1[8:5];
      end else if (d1[1:0] == 2'd1) begin
        e_a2 = (d1 & 32'hFFFF_FC00) | ((va & 32'h000F_F000) >> 10);
        d2 = rd(e_a2);
        e_reads = 2;
        m_last_dom = d1[8:5];
        if (d2[1:0] == 2'd1) begin
          map = 2; e_pa = {d2[31:16], va[15:0]}; e_perm = d2[11:0] & 12'hFFC;
        end else if (d2[1:0] == 2'd2) begin
          map = 1; e_pa = {d2[31:12], va[11:0]}; e_perm = d2[11:0] & 12'hFFC;
        end else begin
          e_flt = 2'd2;
        end
      end else begin
        e_flt = 2'd1;
      end
      if (map != 0) begin
        m_vld[m_rr] = 1'b1;
        m_map[m_rr] = map;
        m_va[m_rr] = va & mk(map);
        m_pa[m_rr] = e_pa & mk(map);
        m_perm[m_rr] = e_perm;
        m_dom[m_rr] = m_last_dom;
        m_rr = (m_rr + 1) % NE;
      end
    end
    addr_log.delete();
    req_i = 1'b1;
    va_i = va;
    do begin
      @(negedge clk_i);
      req_i = 1'b0;
      cyc++;
    end while (!done_o && cyc < 100);
    chk(tag, "done", {31'b0, done_o}, 32'd1);
    chk(tag, "fault", {30'b0, fault_o}, {30'b0, e_flt});
    chk(tag, "pa", pa_o, e_pa);
    chk(tag, "perm", {20'b0, perm_o}, {20'b0, e_perm});
    chk(tag, "dom", {28'b0, dom_o}, {28'b0, m_last_dom});
    chk(tag, "hit", {31'b0, hit_o}, {31'b0, e_hit});
    chk(tag, "reads", addr_log.size(), e_reads);
    if (e_hit) chk("R7", "hit latency", cyc, 1);
    if (e_reads >= 1 && addr_log.size() >= 1) chk("R1", "l1 addr", addr_log[0], e_a1);
    if (e_reads == 2 && addr_log.size() == 2) chk("R4", "l2 addr", addr_log[1], e_a2);
  endtask

  task automatic do_inv_all();
    inv_all_i = 1'b1;
    @(negedge clk_i);
    inv_all_i = 1'b0;
    for (int i = 0; i < NE; i++) m_vld[i] = 1'b0;
  endtask

  task automatic do_inv_va(logic [31:0] a);
    inv_addr_i = a;
    inv_va_i = 1'b1;
    @(negedge clk_i);
    inv_va_i = 1'b0;
    for (int i = 0; i < NE; i++)
      if (m_vld[i] && ((a & mk(m_map[i])) == m_va[i])) m_vld[i] = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < NE; i++) m_vld[i] = 1'b0;
    mem[l1a(32'h0030_0000)] = 32'hABC0_0D4E;
    mem[l1a(32'h0050_0000)] = 32'h1234_5673;
    mem[l1a(32'h0060_0000)] = 32'h0020_0461;
    mem[32'h0020_0454] = 32'h7777_0AB5;
    mem[32'h0020_048C] = 32'h8888_9556;
    mem[32'h0020_0500] = 32'hFFFF_FFFF;
    for (int k = 8; k <= 12; k++)
      mem[l1a(32'(k) << 20)] = (32'(k) << 24) | (32'(k) << 5) | 32'h0000_0C02;

    repeat (3) @(negedge clk_i);
    chk("R11", "reset done", {31'b0, done_o}, 32'd0);
    chk("R11", "reset dom", {28'b0, dom_o}, 32'd0);
    chk("R12", "reset mem_req", {31'b0, mem_req_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R7", "ready after reset", {31'b0, ready_o}, 32'd1);

    mem_lat = 0;
    xlat(32'h0031_2345, "R3");
    xlat(32'h0030_0ABC, "R7");
    mem_lat = 2;
    xlat(32'h0040_0000, "R2");
    xlat(32'h0050_0010, "R2");
    xlat(32'h0061_5678, "R6");
    xlat(32'h0062_3ABC, "R6");
    xlat(32'h0050_0020, "R11");
    mem_lat = 3;
    xlat(32'h0063_0000, "R5");
    xlat(32'h0064_0004, "R5");
    xlat(32'h0061_0000, "R7");
    xlat(32'h0062_3000, "R7");
    xlat(32'h0040_0008, "R12");

    do_inv_va(32'h0061_1234);
    xlat(32'h0061_5678, "R10");
    xlat(32'h0030_0000, "R10");
    xlat(32'h0062_3004, "R10");

    mem_lat = 0;
    do_inv_all();
    xlat(32'h0030_0000, "R9");
    xlat(32'h0062_3004, "R9");

    do_inv_all();
    for (int k = 8; k <= 11; k++) xlat(32'(k) << 20, "R8");
    xlat((32'd8 << 20) + 32'h4, "R8");
    xlat(32'd12 << 20, "R8");
    xlat(32'd8 << 20, "R8");
    xlat((32'd9 << 20) + 32'h10, "R8");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule